// File: doc/BRIEF.md
# Two-Pass Subranging Conversion Sequencer

This block is the digital timing engine of a sampling converter that resolves each sample in two passes of a single 9-bit flash quantizer. It runs from a free-running internal clock. A rising edge on the convert-start input freezes the input sample-and-hold and pulls the idle flag low. The block then walks through a fixed, cycle-counted schedule. It fires the quantizer start strobe, captures the coarse code, and presents that code to the 16-bit DAC with the low bits cleared. It waits for the DAC and the residue amplifier to settle. It then swaps the quantizer input from the held signal to the residue amplifier and fires the quantizer a second time.

At the moment of the swap, the residue sample-and-hold is frozen and the input sample-and-hold is released back to tracking. The acquisition of the next sample therefore overlaps the second pass. After the fine code is captured, a correction adder merges the two codes, removes the deliberate residue offset and clamps to the 16-bit two's complement range. The result goes to the output latch. The idle flag returns high only one cycle after the new word is already on the output.

Top module: `subrange_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, convIdle is 1, inputHold is 0, residueHold is 0, swInput is 1, swResidue is 0, and dataOut is 0x0000.
- R2: A low-to-high change on convStart while idle is seen after a SYNC_STAGES-flop synchronizer. convIdle falls and inputHold rises SYNC_STAGES clock edges after the first edge that samples convStart high.
- R3: coarseStrobe is a one-cycle pulse, issued exactly twice per conversion: on the first cycle of the first pass, and on the first cycle of the second pass, COARSE_CYC+SETTLE_CYC cycles later.
- R4: dacLoad pulses on the first settling cycle, COARSE_CYC cycles after the first coarseStrobe. dacWord then equals the captured 9-bit coarse code in bits 15:7, with bits 6:0 zero. dacWord does not change at any other time.
- R5: During the second pass, swInput is 0, swResidue is 1, residueHold is 1 and inputHold is 0. swInput and swResidue are never both 1.
- R6: The result equals coarse×128 + fine − RES_OFFSET (default 64). Here coarse is the first code read as 9-bit two's complement and fine is the second code read as unsigned.
- R7: A result above 32767 is stored as 0x7FFF, and a result below −32768 is stored as 0x8000.
- R8: latchUpdate pulses for one cycle, and dataOut takes the new word at the end of that cycle. dataOut changes at no other time. convIdle rises one cycle after the new word is visible.
- R9: A convStart rising edge that arrives while convIdle is 0 is ignored. It starts no second conversion and adds no strobe.
- R10: convIdle is low for exactly COARSE_CYC+SETTLE_CYC+FINE_CYC+2 cycles per conversion, and inputHold is 0 again when it returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| convStart | input | 1 | Asynchronous convert-start request, rising edge active |
| coarseIn | input | 9 | Code returned by the 9-bit flash quantizer |
| convIdle | output | 1 | High when idle, low while a conversion runs |
| inputHold | output | 1 | Input sample-and-hold in hold when 1, tracking when 0 |
| coarseStrobe | output | 1 | Start pulse for the flash quantizer |
| dacLoad | output | 1 | Load pulse for the 16-bit DAC |
| dacWord | output | 16 | DAC code: coarse code on top, zeros below |
| swInput | output | 1 | Closes the path from the held input to the quantizer |
| swResidue | output | 1 | Closes the path from the residue amplifier to the quantizer |
| residueHold | output | 1 | Residue sample-and-hold in hold when 1 |
| latchUpdate | output | 1 | Pulse marking the output latch update |
| dataOut | output | 16 | Output latch, two's complement result |

## Verification
The in-line assertions watch, on every clock, the properties that are local in time. The two quantizer switches are never closed together. The second-pass configuration always pairs residue hold with input tracking. Quantizer strobes are single-cycle. A conversion only ever begins from idle. The output latch and DAC word move only on their own strobes, and the idle flag never rises until two cycles after a latch update. The exact schedule can only be shown by the bench's conversions: the synchronizer latency, the strobe and load positions, and the busy length. So can the arithmetic of the merge, including the offset removal and both saturation limits, and the fact that a second start edge during busy leaves the schedule untouched.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COARSE,
    ST_SETTLE,
    ST_FINE,
    ST_MERGE,
    ST_DONE
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capCoarse;
    logic capFine;
    logic merge;
  } dpStrobe_t;

endpackage

// File: rtl/subrange_ctrl.sv
module subrange_ctrl
  import subrange_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int COARSE_CYC  = 20,
  parameter int SETTLE_CYC  = 13,
  parameter int FINE_CYC    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       convStart,
  output dpStrobe_t  strb,
  output logic       convIdle,
  output logic       inputHold,
  output logic       coarseStrobe,
  output logic       dacLoad,
  output logic       swInput,
  output logic       swResidue,
  output logic       residueHold,
  output logic       latchUpdate
);

  localparam int MAX_CYC = (COARSE_CYC > SETTLE_CYC) ?
                           ((COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC) :
                           ((SETTLE_CYC > FINE_CYC) ? SETTLE_CYC : FINE_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  // start-edge synchronizer
  logic syncOut;
  logic lastLevel;
  logic startEdge;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic syncReg;
      always_ff @(posedge clk) begin
        if (rst) syncReg <= 1'b0;
        else     syncReg <= convStart;
      end
      assign syncOut = syncReg;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], convStart};
      end
      assign syncOut = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= 1'b0;
    else     lastLevel <= syncOut;
  end

  assign startEdge = syncOut & ~lastLevel;

  // phase sequencer
  seqState_t      state, nextState;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic           phaseLast;

  always_comb begin
    case (state)
      ST_COARSE: lastCnt = CNT_W'(COARSE_CYC - 1);
      ST_SETTLE: lastCnt = CNT_W'(SETTLE_CYC - 1);
      ST_FINE:   lastCnt = CNT_W'(FINE_CYC - 1);
      default:   lastCnt = '0;
    endcase
  end

  assign phaseLast = (cnt == lastCnt);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (startEdge) nextState = ST_COARSE;
      ST_COARSE: if (phaseLast) nextState = ST_SETTLE;
      ST_SETTLE: if (phaseLast) nextState = ST_FINE;
      ST_FINE:   if (phaseLast) nextState = ST_MERGE;
      ST_MERGE:  nextState = ST_DONE;
      ST_DONE:   nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE || phaseLast) cnt <= '0;
      else                               cnt <= cnt + 1'b1;
    end
  end

  // Moore outputs
  always_comb begin
    convIdle     = 1'b0;
    inputHold    = 1'b0;
    coarseStrobe = 1'b0;
    dacLoad      = 1'b0;
    swInput      = 1'b1;
    swResidue    = 1'b0;
    residueHold  = 1'b0;
    strb         = '0;
    case (state)
      ST_IDLE: convIdle = 1'b1;
      ST_COARSE: begin
        inputHold      = 1'b1;
        coarseStrobe   = (cnt == '0);
        strb.capCoarse = phaseLast;
      end
      ST_SETTLE: begin
        inputHold = 1'b1;
        dacLoad   = (cnt == '0);
      end
      ST_FINE: begin
        swInput      = 1'b0;
        swResidue    = 1'b1;
        residueHold  = 1'b1;
        coarseStrobe = (cnt == '0);
        strb.capFine = phaseLast;
      end
      ST_MERGE: strb.merge = 1'b1;
      default: ;
    endcase
  end

  assign latchUpdate = strb.merge;

  // checks
  p_switch_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(swInput && swResidue));

  p_phase2_cfg_r5: assert property (@(posedge clk) disable iff (rst)
    swResidue |-> (residueHold && !inputHold));

  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    coarseStrobe |=> !coarseStrobe);

  p_start_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COARSE && cnt == '0) |-> $past(convIdle));

  p_idle_after_data_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(convIdle) |-> $past(latchUpdate, 2));

  p_idle_tracks_r1: assert property (@(posedge clk) disable iff (rst)
    convIdle |-> (!inputHold && !residueHold && swInput));

endmodule

// File: rtl/subrange_dp.sv
module subrange_dp
  import subrange_pkg::*;
#(
  parameter int COARSE_W   = 9,
  parameter int FINE_W     = 9,
  parameter int OUT_W      = 16,
  parameter int RES_OFFSET = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strb,
  input  logic [COARSE_W-1:0] coarseIn,
  output logic [OUT_W-1:0]    dacWord,
  output logic [OUT_W-1:0]    dataOut
);

  localparam int SHIFT = OUT_W - COARSE_W;
  localparam int EXT_W = OUT_W + 2;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM - EXT_W'(1);

  logic [COARSE_W-1:0] coarseReg;
  logic [FINE_W-1:0]   fineReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseReg <= '0;
      fineReg   <= '0;
    end else begin
      if (strb.capCoarse) coarseReg <= coarseIn;
      if (strb.capFine)   fineReg   <= FINE_W'(coarseIn);
    end
  end

  assign dacWord = {coarseReg, {SHIFT{1'b0}}};

  // error correction: weight coarse, add fine, remove offset, clamp
  logic signed [EXT_W-1:0] coarseExt;
  logic signed [EXT_W-1:0] fineExt;
  logic signed [EXT_W-1:0] sumExt;
  logic [OUT_W-1:0]        merged;

  assign coarseExt = {{(EXT_W - COARSE_W){coarseReg[COARSE_W-1]}}, coarseReg} <<< SHIFT;
  assign fineExt   = {{(EXT_W - FINE_W){1'b0}}, fineReg};
  assign sumExt    = coarseExt + fineExt - EXT_W'(RES_OFFSET);

  always_comb begin
    if (sumExt > POS_LIM)      merged = POS_LIM[OUT_W-1:0];
    else if (sumExt < NEG_LIM) merged = NEG_LIM[OUT_W-1:0];
    else                       merged = sumExt[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)             dataOut <= '0;
    else if (strb.merge) dataOut <= merged;
  end

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strb.merge |=> $stable(dataOut));

  p_dac_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.capCoarse |=> $stable(dacWord));

endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
  import subrange_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int COARSE_CYC  = 20,
  parameter int SETTLE_CYC  = 13,
  parameter int FINE_CYC    = 16,
  parameter int RES_OFFSET  = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        convStart,
  input  logic [8:0]  coarseIn,
  output logic        convIdle,
  output logic        inputHold,
  output logic        coarseStrobe,
  output logic        dacLoad,
  output logic [15:0] dacWord,
  output logic        swInput,
  output logic        swResidue,
  output logic        residueHold,
  output logic        latchUpdate,
  output logic [15:0] dataOut
);

  dpStrobe_t strb;

  subrange_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .COARSE_CYC (COARSE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .FINE_CYC   (FINE_CYC)
  ) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .convStart   (convStart),
    .strb        (strb),
    .convIdle    (convIdle),
    .inputHold   (inputHold),
    .coarseStrobe(coarseStrobe),
    .dacLoad     (dacLoad),
    .swInput     (swInput),
    .swResidue   (swResidue),
    .residueHold (residueHold),
    .latchUpdate (latchUpdate)
  );

  subrange_dp #(
    .COARSE_W  (9),
    .FINE_W    (9),
    .OUT_W     (16),
    .RES_OFFSET(RES_OFFSET)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .coarseIn(coarseIn),
    .dacWord (dacWord),
    .dataOut (dataOut)
  );

endmodule

// File: tb/test_subrange_seq.sv
module test_subrange_seq;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC_N  = 2;
  localparam int C_CYC   = 20;
  localparam int T_CYC   = 13;
  localparam int F_CYC   = 16;
  localparam int OFFSET  = 64;
  localparam int S_IDX   = SYNC_N;
  localparam int LOAD_IDX = S_IDX + C_CYC;
  localparam int P2_IDX  = LOAD_IDX + T_CYC;
  localparam int LAT_IDX = P2_IDX + F_CYC;
  localparam int END_IDX = LAT_IDX + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        convStart = 1'b0;
  logic [8:0]  coarseVal = '0;
  logic [8:0]  fineVal = '0;
  logic [8:0]  coarseIn;
  logic        convIdle, inputHold, coarseStrobe, dacLoad;
  logic        swInput, swResidue, residueHold, latchUpdate;
  logic [15:0] dacWord, dataOut;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [15:0] prevOut = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // analog stand-in: quantizer sees held input or residue by switch state
  assign coarseIn = swResidue ? fineVal : coarseVal;

  subrange_seq #(
    .SYNC_STAGES(SYNC_N),
    .COARSE_CYC (C_CYC),
    .SETTLE_CYC (T_CYC),
    .FINE_CYC   (F_CYC),
    .RES_OFFSET (OFFSET)
  ) i_subrange_seq (
    .clk(clk), .rst(rst), .convStart(convStart), .coarseIn(coarseIn),
    .convIdle(convIdle), .inputHold(inputHold), .coarseStrobe(coarseStrobe),
    .dacLoad(dacLoad), .dacWord(dacWord), .swInput(swInput),
    .swResidue(swResidue), .residueHold(residueHold),
    .latchUpdate(latchUpdate), .dataOut(dataOut)
  );

  function automatic logic [15:0] expectWord(logic [8:0] cv, logic [8:0] fv);
    int c = cv[8] ? int'(cv) - 512 : int'(cv);
    int r = c * 128 + int'(fv) - OFFSET;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  function automatic bit isClamped(logic [8:0] cv, logic [8:0] fv);
    int c = cv[8] ? int'(cv) - 512 : int'(cv);
    int r = c * 128 + int'(fv) - OFFSET;
    return (r > 32767) || (r < -32768);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runConv(logic [8:0] cv, logic [8:0] fv, bit reStart);
    logic [15:0] expW = expectWord(cv, fv);
    int strobes = 0;
    int busyCyc = 0;
    int lateStrobe = 0;
    coarseVal = cv;
    fineVal   = fv;
    convStart = 1'b1;
    for (int i = 0; i <= END_IDX + 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (coarseStrobe && i <= END_IDX) strobes++;
      if (coarseStrobe && i > END_IDX) lateStrobe++;
      if (!convIdle && i <= END_IDX) busyCyc++;
      if (i == S_IDX - 1)
        check(convIdle == 1'b1, "R2", "idle before sync latency", 32'(convIdle), 1);
      if (i == S_IDX)
        check(!convIdle && inputHold && coarseStrobe, "R2", "start of first pass",
              {convIdle, inputHold, coarseStrobe}, 3'b011);
      if (i == LOAD_IDX)
        check(dacLoad && dacWord == {cv, 7'b0}, "R4", "dac load word",
              {15'b0, dacLoad, dacWord}, {15'b0, 1'b1, cv, 7'b0});
      if (i == P2_IDX)
        check(!swInput && swResidue && residueHold && !inputHold && coarseStrobe,
              "R5", "second pass switches", {swInput, swResidue, residueHold, inputHold, coarseStrobe},
              5'b01101);
      if (i == LAT_IDX)
        check(latchUpdate && dataOut == prevOut, "R8", "latch pulse, old data",
              {15'b0, latchUpdate, dataOut}, {15'b0, 1'b1, prevOut});
      if (i == LAT_IDX + 1) begin
        check(dataOut == expW, isClamped(cv, fv) ? "R7" : "R6", "merged word",
              32'(dataOut), 32'(expW));
        check(!convIdle, "R8", "busy still low with new data", 32'(convIdle), 0);
      end
      if (i == END_IDX)
        check(convIdle && !inputHold, "R10", "idle and tracking at end",
              {convIdle, inputHold}, 2'b10);
      if (i == 3) convStart = 1'b0;
      if (reStart && i == 10) convStart = 1'b1;
      if (reStart && i == 14) convStart = 1'b0;
    end
    check(strobes == 2, "R3", "quantizer strobes per conversion", 32'(strobes), 2);
    check(busyCyc == C_CYC + T_CYC + F_CYC + 2, "R10", "busy length",
          32'(busyCyc), 32'(C_CYC + T_CYC + F_CYC + 2));
    if (reStart)
      check(lateStrobe == 0 && convIdle, "R9", "edge during busy ignored",
            32'(lateStrobe), 0);
    prevOut = expW;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(convIdle && !inputHold && !residueHold && swInput && !swResidue && dataOut == 16'h0,
          "R1", "state during reset", {convIdle, inputHold, residueHold, swInput, swResidue, dataOut},
          {5'b10010, 16'h0});
    rst = 1'b0;
    @(negedge clk);
    check(convIdle && !inputHold && dataOut == 16'h0, "R1", "state after reset",
          {convIdle, inputHold, dataOut}, {2'b10, 16'h0});

    // directed corners
    runConv(9'h000, 9'd64,  1'b0);   // R6 midscale -> 0x0000
    runConv(9'h0FF, 9'd191, 1'b0);   // R6 exactly 0x7FFF
    runConv(9'h0FF, 9'd511, 1'b1);   // R7 clamp high, R9 re-edge
    runConv(9'h100, 9'd64,  1'b0);   // R6 exactly 0x8000
    runConv(9'h100, 9'd0,   1'b0);   // R7 clamp low
    runConv(9'h1FF, 9'd63,  1'b1);   // R6 -129, R9

    // random conversions
    for (int k = 0; k < 24; k++) begin
      logic [8:0] cv = 9'($urandom);
      logic [8:0] fv = 9'($urandom);
      runConv(cv, fv, 1'($urandom));
      repeat (int'($urandom % 4)) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule